// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer controlled through one 32-bit register on a simple write-strobe and read-data interface. The low 24 bits of every write become the reload value. Two 2-bit fields in the upper byte control the timer, and neither acts on a plain write. Software starts or stops the timer by writing the value 1 into the enable field and then writing the value 2 into it on the next register write. The same two-write key on the service field restarts the countdown. The enable key is a toggle: each completed sequence flips the running state.

While the timer runs, a divide-by-256 prescaler on the bus clock decrements a 24-bit countdown. A reload value of N therefore gives a timeout of 256·N bus cycles. When the countdown runs out, the block raises a one-cycle expiry pulse and sets a sticky timeout flag. A system can route either one to an interrupt or to a reset source. Reads return the running state in the top bit and the current reload value in the low bits.

Top module: `keyed_watchdog`

## Requirements
- R1: After a synchronous active-low reset, the timer is stopped, the reload value is zero, both key sequences are disarmed, and `rd_data`, `expire_pulse` and `timeout_flag` are all zero.
- R2: Every write stores `wr_data[23:0]` as the reload value. `rd_data` returns the reload value in bits 23:0, zeros in bits 30:24, and the running state in bit 31.
- R3: A write carrying 1 in bits 25:24, followed by the next register write carrying 2 in bits 25:24, toggles the running state. A start loads the countdown from the reload value of the completing write and clears the prescaler.
- R4: A key sequence fires only when the completing write directly follows the arming write. A write of 2 without a preceding 1 does nothing, and any other field value in between (0 or 3) disarms the sequence.
- R5: The enable field (bits 25:24) and the service field (bits 27:26) keep separate key states, so a write can arm one field while it completes or holds the other.
- R6: Once started or serviced with reload N ≥ 1, the timer raises `expire_pulse` for exactly one cycle, 256·N cycles after the completing write edge. At that same edge it sets `timeout_flag`, which stays set afterwards.
- R7: A service sequence (1 then 2 in bits 27:26) completed while the timer runs reloads the countdown from that write, clears the prescaler and clears `timeout_flag`.
- R8: Stopping the timer clears `timeout_flag` and freezes the countdown. While stopped, no expiry occurs and service sequences have no effect.
- R9: Starting the timer with a reload value of 0 expires at the first prescaler wrap, 256 cycles after the completing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Write data: service key [27:26], enable key [25:24], reload [23:0] |
| rd_data | output | 32 | Read data: running [31], zero [30:24], reload [23:0] |
| expire_pulse | output | 1 | One-cycle pulse on countdown expiry |
| timeout_flag | output | 1 | Sticky expiry flag |

## Verification
The bench attacks the key sequences at their edges: a broken sequence (1, 3, 2), a gap with 0 in the field, and a lone 2 must all leave the timer stopped. A detector that only looked for a 2 or remembered stale arming would start the timer at one of these. Expiry is measured to the exact cycle for reload values 0, 1 and 2, and after a service issued partway through a count. An off-by-one prescaler or a countdown that reloads one short would move the pulse by 256 cycles or by one. Further checks confirm that a stopped timer ignores service keys and never expires, and that one write can arm one field while it completes the other. A design that shared key state between the fields would miss the completion or fire spuriously.

// File: rtl/wdt_pkg.sv
// Package: field positions and key codes shared by the watchdog modules.
// Assumes a 32-bit register with the reload value in the low bits.
package wdt_pkg;
    localparam int REG_W      = 32;
    localparam int RELOAD_W   = 24;
    localparam int PRESCALE_W = 8;
    localparam int EN_LSB     = 24;
    localparam int SVC_LSB    = 26;
    localparam int STATUS_BIT = 31;
    localparam int KEY_W      = 2;
    localparam logic [KEY_W-1:0] KEY_ARM  = 2'd1;
    localparam logic [KEY_W-1:0] KEY_FIRE = 2'd2;
endpackage

// File: rtl/wdt_key_seq.sv
// Module: two-write key detector for one control field.
// A write with KEY_ARM arms it. The next write fires it if the field holds
// KEY_FIRE. Any write re-evaluates the arming. Idle cycles keep the state.
module wdt_key_seq
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] field,
    output logic             fire
);
    logic armed;

    // Track whether the previous register write armed this field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (wr_en)
            armed <= (field == KEY_ARM);
    end

    // Complete the sequence on an armed write that carries the fire code.
    always_comb fire = wr_en && armed && (field == KEY_FIRE);
endmodule

// File: rtl/wdt_prescaler.sv
// Module: free-running divider that emits a tick once every 2**W cycles
// while run is high. A clear restarts the division at zero.
module wdt_prescaler #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    logic [W-1:0] cnt;

    // Advance the divider while running; restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clear)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end

    // Tick on the last count of each period.
    always_comb tick = run && (&cnt);
endmodule

// File: rtl/wdt_countdown.sv
// Module: reloadable countdown with a sticky expiry flag and a one-cycle pulse.
// Assumes a tick arrives only while running. Load has priority over the tick.
// A zero count expires on the next tick if the flag is still clear.
module wdt_countdown #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clr_flag,
    output logic         pulse,
    output logic         flag
);
    logic [W-1:0] count;

    // Count down on ticks, reload on demand, and record expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            flag  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (load) begin
                count <= load_val;
                flag  <= 1'b0;
            end else if (clr_flag) begin
                flag <= 1'b0;
            end else if (tick) begin
                if (count > W'(1)) begin
                    count <= count - 1'b1;
                end else if (count == W'(1)) begin
                    count <= '0;
                    flag  <= 1'b1;
                    pulse <= 1'b1;
                end else if (!flag) begin
                    flag  <= 1'b1;
                    pulse <= 1'b1;
                end
            end
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R6
    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> flag); // R6
    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count)); // R8
endmodule

// File: rtl/keyed_watchdog.sv
// Module: top of the keyed watchdog. It holds the running state and the reload
// value, decodes the two key fields, and drives the prescaler and countdown.
// Assumes one write per wr_en cycle; rd_data is valid at all times.
module keyed_watchdog
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             expire_pulse,
    output logic             timeout_flag
);
    localparam int PAD_W = STATUS_BIT - RELOAD_W;

    logic                running;
    logic [RELOAD_W-1:0] reload_q;
    logic                en_fire;
    logic                svc_fire;
    logic                do_load;
    logic                do_stop;
    logic                tick;

    wdt_key_seq u_en_key (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .field (wr_data[EN_LSB +: KEY_W]),
        .fire  (en_fire)
    );

    wdt_key_seq u_svc_key (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .field (wr_data[SVC_LSB +: KEY_W]),
        .fire  (svc_fire)
    );

    // Start or service loads the countdown; a toggle while running stops it.
    always_comb begin
        do_load = (en_fire && !running) || (svc_fire && running && !en_fire);
        do_stop = en_fire && running;
    end

    // Keep the running state and capture the reload value on every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            reload_q <= '0;
        end else if (wr_en) begin
            reload_q <= wr_data[RELOAD_W-1:0];
            if (en_fire)
                running <= !running;
        end
    end

    wdt_prescaler #(.W(PRESCALE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .clear (do_load),
        .tick  (tick)
    );

    wdt_countdown #(.W(RELOAD_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .tick     (tick),
        .load     (do_load),
        .load_val (wr_data[RELOAD_W-1:0]),
        .clr_flag (do_stop),
        .pulse    (expire_pulse),
        .flag     (timeout_flag)
    );

    // Assemble the read word: status, zero pad, reload value.
    always_comb rd_data = {running, {PAD_W{1'b0}}, reload_q};

    AST_TOGGLE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (running != $past(running)) |->
            ($past(wr_en) && $past(wr_data[EN_LSB +: KEY_W]) == KEY_FIRE)); // R3
    AST_FLAG_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !timeout_flag); // R8
endmodule

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        expire_pulse;
    logic        timeout_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    keyed_watchdog dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .expire_pulse (expire_pulse),
        .timeout_flag (timeout_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] word(input logic [1:0] svc, input logic [1:0] en,
                                         input logic [23:0] rel);
        return {4'b0, svc, en, rel};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    // Count negedges after the last write until a pulse is seen; 0 if none.
    task automatic wait_pulse(input int limit, output int k);
        k = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (expire_pulse) begin
                k = i;
                break;
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "rd_data after reset", rd_data, 32'h0);
        check("R1", "flag after reset", {31'b0, timeout_flag}, 32'h0);
        check("R1", "pulse after reset", {31'b0, expire_pulse}, 32'h0);
    endtask

    task automatic t_readback();
        do_reset();
        wr(32'hF0AB_CDEF & word(2'd0, 2'd0, 24'hABCDEF) | 32'h7000_0000);
        check("R2", "reload readback, pad zero", rd_data, 32'h00AB_CDEF);
        wr(word(2'd0, 2'd3, 24'h000123));
        check("R2", "reload overwritten", rd_data, 32'h0000_0123);
    endtask

    task automatic t_enable_toggle();
        do_reset();
        wr(word(2'd0, 2'd1, 24'd5));
        check("R3", "armed only, still stopped", {31'b0, rd_data[31]}, 32'h0);
        wr(word(2'd0, 2'd2, 24'd5));
        check("R3", "started", rd_data, 32'h8000_0005);
        wr(word(2'd0, 2'd1, 24'd5));
        wr(word(2'd0, 2'd2, 24'd5));
        check("R3", "toggled off", {31'b0, rd_data[31]}, 32'h0);
    endtask

    task automatic t_broken_key();
        do_reset();
        wr(word(2'd0, 2'd1, 24'd4));
        wr(word(2'd0, 2'd3, 24'd4));
        wr(word(2'd0, 2'd2, 24'd4));
        check("R4", "1,3,2 must not start", {31'b0, rd_data[31]}, 32'h0);
        wr(word(2'd0, 2'd1, 24'd4));
        wr(word(2'd0, 2'd0, 24'd4));
        wr(word(2'd0, 2'd2, 24'd4));
        check("R4", "1,0,2 must not start", {31'b0, rd_data[31]}, 32'h0);
        wr(word(2'd0, 2'd2, 24'd4));
        check("R4", "lone 2 must not start", {31'b0, rd_data[31]}, 32'h0);
    endtask

    task automatic t_expiry();
        int k;
        do_reset();
        wr(word(2'd0, 2'd1, 24'd2));
        wr(word(2'd0, 2'd2, 24'd2));
        wait_pulse(1000, k);
        check("R6", "expiry cycle, reload 2", k, 512);
        @(negedge clk);
        check("R6", "pulse one cycle wide", {31'b0, expire_pulse}, 32'h0);
        check("R6", "flag sticky", {31'b0, timeout_flag}, 32'h1);
        wait_pulse(600, k);
        check("R6", "no second pulse", k, 0);
        check("R6", "flag still set", {31'b0, timeout_flag}, 32'h1);
        do_reset();
        wr(word(2'd0, 2'd1, 24'd1));
        wr(word(2'd0, 2'd2, 24'd1));
        wait_pulse(600, k);
        check("R6", "expiry cycle, reload 1", k, 256);
    endtask

    task automatic t_zero_reload();
        int k;
        do_reset();
        wr(word(2'd0, 2'd1, 24'd0));
        wr(word(2'd0, 2'd2, 24'd0));
        wait_pulse(600, k);
        check("R9", "expiry cycle, reload 0", k, 256);
    endtask

    task automatic t_service();
        int k;
        do_reset();
        wr(word(2'd0, 2'd1, 24'd2));
        wr(word(2'd0, 2'd2, 24'd2));
        repeat (300) @(negedge clk);
        wr(word(2'd1, 2'd0, 24'd2));
        wr(word(2'd2, 2'd0, 24'd2));
        wait_pulse(1000, k);
        check("R7", "expiry restarted by service", k, 512);
        @(negedge clk);
        check("R7", "flag set before second service", {31'b0, timeout_flag}, 32'h1);
        wr(word(2'd1, 2'd0, 24'd1));
        wr(word(2'd2, 2'd0, 24'd1));
        check("R7", "service clears flag", {31'b0, timeout_flag}, 32'h0);
        wait_pulse(600, k);
        check("R7", "expiry after service, reload 1", k, 256);
    endtask

    task automatic t_independent();
        int k;
        do_reset();
        wr(word(2'd0, 2'd1, 24'd3));
        wr(word(2'd1, 2'd2, 24'd3));
        check("R5", "enable completes while service arms", {31'b0, rd_data[31]}, 32'h1);
        repeat (100) @(negedge clk);
        wr(word(2'd2, 2'd0, 24'd1));
        wait_pulse(600, k);
        check("R5", "service completes after enable write", k, 256);
    endtask

    task automatic t_stopped();
        int k;
        do_reset();
        wr(word(2'd0, 2'd1, 24'd1));
        wr(word(2'd0, 2'd2, 24'd1));
        wait_pulse(600, k);
        @(negedge clk);
        wr(word(2'd0, 2'd1, 24'd1));
        wr(word(2'd0, 2'd2, 24'd1));
        check("R8", "stop clears flag", {31'b0, timeout_flag}, 32'h0);
        wr(word(2'd1, 2'd0, 24'd1));
        wr(word(2'd2, 2'd0, 24'd1));
        check("R8", "service keeps timer stopped", {31'b0, rd_data[31]}, 32'h0);
        wait_pulse(1000, k);
        check("R8", "no expiry while stopped", k, 0);
        check("R8", "flag clear while stopped", {31'b0, timeout_flag}, 32'h0);
    endtask

    initial begin
        t_reset();
        t_readback();
        t_enable_toggle();
        t_broken_key();
        t_expiry();
        t_zero_reload();
        t_service();
        t_independent();
        t_stopped();
        done = 1;
    end

    initial begin
        for (int c = 0; c < WATCHDOG_CYCLES && !done; c++) @(negedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule